// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block makes the serial audio bit clock from the system clock. A 4-bit ratio code picks one of an irregular set of divide ratios, from 1 up to 32. Two of these ratios are half-integers (1.5 and 5.5). When the block is the timing master, the divided clock drives one bit-clock output, which the converter paths in both directions share. When the block is a timing slave, the divider is bypassed and a bit clock from the host is passed to the output unchanged.

Internally all timing is counted in half-cycles of the system clock. A counter runs on the rising edge and decides, for each half-cycle slot, whether the output is high. A flop on the rising edge holds the level for the low half of the system clock. A flop on the falling edge holds the level for the high half. A mux driven by the system clock level picks between the two, so odd half-cycle periods come out exactly.

The counter runs over a window: one output period for even half-cycle counts, and two periods for odd counts. A new ratio code is accepted only where a window wraps, so the output never shows a shortened phase. A one-cycle strobe, synchronous to the system clock, marks every rising edge of the bit clock in both modes.

Top module: `bitclk_div`

## Requirements
- R1: In master mode, ratio codes 0 to 12 give output periods of 2, 3, 4, 6, 8, 11, 12, 16, 22, 24, 32, 44 and 48 system-clock half-cycles, in code order.
- R2: Ratio codes 13, 14 and 15 all give an output period of 64 half-cycles (divide by 32).
- R3: With code 0 the output follows the system clock: high while the system clock is high and low while it is low.
- R4: For every code, the output stays high for floor(P/2) half-cycles of each period of P half-cycles. For the half-integer codes 1 and 5 this gives high/low phases of 1/2 and 5/6 half-cycles.
- R5: After the ratio code changes, every output period, measured from rising edge to rising edge, has either the full old length or the full new length, with high time floor(P/2). At most two old-length periods appear before the new length is established.
- R6: In master mode, the strobe is high for exactly one system-clock cycle for each rising edge of the output. Over a long interval, the strobe count and the rising-edge count differ by at most one.
- R7: In slave mode the output equals the external bit-clock input at all times, and the ratio code has no effect on it.
- R8: In slave mode, each rising edge of the external bit clock gives exactly one strobe cycle, within three system-clock cycles.
- R9: While the active-low synchronous reset is low, the output and the strobe are held low in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_code_i | input | 4 | Divide-ratio code |
| master_i | input | 1 | 1 = generate the bit clock, 0 = pass the external bit clock through |
| bclk_ext_i | input | 1 | Bit clock supplied by the host in slave mode |
| bclk_o | output | 1 | Bit-clock output shared by both converter paths |
| bit_stb_o | output | 1 | One system-clock-cycle pulse per bit-clock rising edge |

## Verification
The hardest case to reach is a ratio change that lands partway through a two-period window of an odd half-cycle ratio. That is where a careless divider would truncate a phase. The bench runs the 5.5 ratio until the output is steady, changes the code on a system-clock edge, and then times every following period and high phase on the output against real time. This catches any runt or mixed-length period in the change sequence. A second change, from an even ratio to a longer one, covers the single-period window case.

// File: rtl/bitclk_div_pkg.sv
`timescale 1ns/1ps
package bitclk_div_pkg;

    localparam int CODE_W = 4;                  // ratio code width
    localparam int HALF_W = 7;                  // period in half-cycles, up to 64
    localparam int CNT_W  = HALF_W - 1;         // window counter, up to 32 cycles
    localparam int SLOT_W = HALF_W + 1;         // half-cycle slot index in a window
    localparam int SYNC_STAGES = 2;             // external clock synchronizer depth

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    // Levels wanted for the two half-cycle slots of one system-clock cycle
    typedef struct packed {
        logic hi_first;   // slot while the system clock is high
        logic hi_second;  // slot while the system clock is low
        logic rise;       // an output rising edge falls in this cycle
    } slot_pair_t;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } clk_mode_e;

    // Output period, in system-clock half-cycles, for a ratio code
    function automatic half_t code_to_half(input code_t code);
        half_t h;
        case (code)
            4'd0:    h = half_t'(2);
            4'd1:    h = half_t'(3);
            4'd2:    h = half_t'(4);
            4'd3:    h = half_t'(6);
            4'd4:    h = half_t'(8);
            4'd5:    h = half_t'(11);
            4'd6:    h = half_t'(12);
            4'd7:    h = half_t'(16);
            4'd8:    h = half_t'(22);
            4'd9:    h = half_t'(24);
            4'd10:   h = half_t'(32);
            4'd11:   h = half_t'(44);
            4'd12:   h = half_t'(48);
            default: h = half_t'(64);
        endcase
        return h;
    endfunction

    // Window length in system-clock cycles: one period if even, two if odd
    function automatic cnt_t window_cycles(input half_t h);
        half_t w;
        w = h[0] ? h : (h >> 1);
        return cnt_t'(w);
    endfunction

    // Phase of a slot within its output period (slot is below 2*h)
    function automatic half_t slot_phase(input slot_idx_t t, input half_t h);
        slot_idx_t hw;
        slot_idx_t r;
        hw = slot_idx_t'(h);
        r  = (t >= hw) ? (t - hw) : t;
        return half_t'(r);
    endfunction

    function automatic logic slot_is_high(input slot_idx_t t, input half_t h);
        return slot_phase(t, h) < (h >> 1);
    endfunction

    function automatic logic slot_is_start(input slot_idx_t t, input half_t h);
        return slot_phase(t, h) == '0;
    endfunction

endpackage

// File: rtl/bitclk_phase_gen.sv
`timescale 1ns/1ps
module bitclk_phase_gen
    import bitclk_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n,
    input  code_t      code_i,
    output cnt_t       cnt_o,
    output half_t      half_o,
    output slot_pair_t slots_o
);

    cnt_t      cnt_q;
    half_t     half_q;
    cnt_t      win_len;
    logic      win_last;
    slot_idx_t t_first;
    slot_idx_t t_second;

    assign win_len  = window_cycles(half_q);
    assign win_last = (cnt_q == win_len - cnt_t'(1));

    // The ratio is reloaded only where the window wraps, which is a period start
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= code_to_half(code_i);
        end else if (win_last) begin
            cnt_q  <= '0;
            half_q <= code_to_half(code_i);
        end else begin
            cnt_q  <= cnt_q + cnt_t'(1);
        end
    end

    always_comb begin
        t_first  = slot_idx_t'(cnt_q) << 1;
        t_second = t_first | slot_idx_t'(1);
        slots_o.hi_first  = slot_is_high(t_first, half_q);
        slots_o.hi_second = slot_is_high(t_second, half_q);
        slots_o.rise      = slot_is_start(t_first, half_q) |
                            slot_is_start(t_second, half_q);
    end

    assign cnt_o  = cnt_q;
    assign half_o = half_q;

endmodule

// File: rtl/bitclk_edge_out.sv
`timescale 1ns/1ps
module bitclk_edge_out
    import bitclk_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n,
    input  slot_pair_t slots_i,
    output logic       hi_first_o,
    output logic       hi_second_o,
    output logic       bclk_o,
    output logic       stb_o
);

    logic first_q;   // updated on the falling edge, shown while clk_i is high
    logic second_q;  // updated on the rising edge, shown while clk_i is low
    logic stb_q;

    always_ff @(negedge clk_i) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= slots_i.hi_first;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            stb_q    <= 1'b0;
        end else begin
            second_q <= slots_i.hi_second;
            stb_q    <= slots_i.rise;
        end
    end

    // Each selected flop is stable whenever the select changes
    assign bclk_o      = clk_i ? first_q : second_q;
    assign stb_o       = stb_q;
    assign hi_first_o  = first_q;
    assign hi_second_o = second_q;

endmodule

// File: rtl/bitclk_ext_sync.sv
`timescale 1ns/1ps
module bitclk_ext_sync
    import bitclk_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic ext_i,
    output logic rise_o
);

    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], ext_i};
    end

    assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

endmodule

// File: rtl/bitclk_div.sv
`timescale 1ns/1ps
module bitclk_div
    import bitclk_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic [3:0] div_code_i,
    input  logic       master_i,
    input  logic       bclk_ext_i,
    output logic       bclk_o,
    output logic       bit_stb_o
);

    cnt_t       win_cnt;
    half_t      half_len;
    slot_pair_t slots;
    logic       gen_bclk;
    logic       gen_stb;
    logic       lvl_first;
    logic       lvl_second;
    logic       ext_rise;
    clk_mode_e  mode;

    assign mode = master_i ? MODE_MASTER : MODE_SLAVE;

    bitclk_phase_gen u_phase (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .code_i  (code_t'(div_code_i)),
        .cnt_o   (win_cnt),
        .half_o  (half_len),
        .slots_o (slots)
    );

    bitclk_edge_out u_edge (
        .clk_i       (clk_i),
        .rst_n       (rst_n),
        .slots_i     (slots),
        .hi_first_o  (lvl_first),
        .hi_second_o (lvl_second),
        .bclk_o      (gen_bclk),
        .stb_o       (gen_stb)
    );

    bitclk_ext_sync u_sync (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .ext_i  (bclk_ext_i),
        .rise_o (ext_rise)
    );

    assign bclk_o    = rst_n & ((mode == MODE_MASTER) ? gen_bclk : bclk_ext_i);
    assign bit_stb_o = (mode == MODE_MASTER) ? gen_stb : ext_rise;

endmodule

// File: rtl/bitclk_div_chk.sv
`timescale 1ns/1ps
module bitclk_div_chk
    import bitclk_div_pkg::*;
(
    input logic  clk_i,
    input logic  rst_n,
    input logic  master_i,
    input logic  bclk_ext_i,
    input logic  bclk_o,
    input logic  bit_stb_o,
    input cnt_t  win_cnt,
    input half_t half_len,
    input logic  lvl_first,
    input logic  lvl_second
);

    logic rst_seen;

    always_ff @(posedge clk_i) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    // R1
    window_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        win_cnt < window_cycles(half_len));

    // R5
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        !$stable(half_len) |-> (win_cnt == '0));

    // R6
    strobe_high_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        (master_i && bit_stb_o) |-> (lvl_first || lvl_second));

    // R7
    bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        !master_i |-> (bclk_o == bclk_ext_i));

    // R9
    always @(negedge clk_i) begin
        if (!rst_n && rst_seen === 1'b1) begin
            reset_quiet_chk: assert (bit_stb_o == 1'b0 && bclk_o == 1'b0);
        end
    end

endmodule

bind bitclk_div bitclk_div_chk u_chk (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .master_i   (master_i),
    .bclk_ext_i (bclk_ext_i),
    .bclk_o     (bclk_o),
    .bit_stb_o  (bit_stb_o),
    .win_cnt    (win_cnt),
    .half_len   (half_len),
    .lvl_first  (lvl_first),
    .lvl_second (lvl_second)
);

// File: tb/bitclk_div_tb.sv
`timescale 1ns/1ps
module bitclk_div_tb;

    logic       clk_i = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] div_code_i = 4'd0;
    logic       master_i = 1'b1;
    logic       bclk_ext_i = 1'b0;
    logic       bclk_o;
    logic       bit_stb_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    int rise_cnt = 0;
    bit rise_en = 1'b0;

    localparam real HALF_NS = 2.5;

    always #2.5 clk_i = ~clk_i;

    bitclk_div u_dut (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .div_code_i (div_code_i),
        .master_i   (master_i),
        .bclk_ext_i (bclk_ext_i),
        .bclk_o     (bclk_o),
        .bit_stb_o  (bit_stb_o)
    );

    always @(posedge bclk_o) if (rise_en) rise_cnt++;

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all R): actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int expect_half(input int code);
        int tbl [16] = '{2, 3, 4, 6, 8, 11, 12, 16, 22, 24, 32, 44, 48, 64, 64, 64};
        return tbl[code];
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_le(input string req, input string what, input int act, input int lim);
        checks++;
        if (act > lim) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected at most %0d", req, what, act, lim);
        end
    endtask

    // Measure one output period starting at the next rising edge
    task automatic measure(output int per, output int hi);
        realtime t1, t2, t3;
        @(posedge bclk_o); t1 = $realtime;
        @(negedge bclk_o); t2 = $realtime;
        @(posedge bclk_o); t3 = $realtime;
        hi  = int'((t2 - t1) / HALF_NS);
        per = int'((t3 - t1) / HALF_NS);
    endtask

    // R9: output and strobe low while reset is held, in both modes
    task automatic t_reset();
        rst_n = 1'b0; master_i = 1'b1; div_code_i = 4'd5; bclk_ext_i = 1'b1;
        repeat (4) @(negedge clk_i);
        check("R9", "master output in reset", int'(bclk_o), 0);
        check("R9", "master strobe in reset", int'(bit_stb_o), 0);
        #1.5;
        check("R9", "master output in reset, clk high", int'(bclk_o), 0);
        master_i = 1'b0;
        @(negedge clk_i); #0.5;
        check("R9", "slave output in reset", int'(bclk_o), 0);
        check("R9", "slave strobe in reset", int'(bit_stb_o), 0);
        master_i = 1'b1; bclk_ext_i = 1'b0;
        @(negedge clk_i); rst_n = 1'b1;
    endtask

    // R1, R2, R4: period and high time of every code
    task automatic t_ratio(input int code);
        int per, hi, exp;
        string req;
        @(negedge clk_i); master_i = 1'b1; div_code_i = 4'(code);
        repeat (80) @(negedge clk_i);
        exp = expect_half(code);
        req = (code >= 13) ? "R2" : "R1";
        for (int k = 0; k < 2; k++) begin
            measure(per, hi);
            check(req, $sformatf("code %0d period", code), per, exp);
            check("R4", $sformatf("code %0d high time", code), hi, exp / 2);
        end
    endtask

    // R3: code 0 follows the system clock
    task automatic t_follow();
        @(negedge clk_i); master_i = 1'b1; div_code_i = 4'd0;
        repeat (40) @(negedge clk_i);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk_i); #1;
            check("R3", "level while clk high", int'(bclk_o), 1);
            @(negedge clk_i); #1;
            check("R3", "level while clk low", int'(bclk_o), 0);
        end
    endtask

    // R5: ratio change mid-window
    task automatic t_change(input int from_code, input int to_code, input int skew);
        int per, hi, old_seen, from_h, to_h;
        from_h = expect_half(from_code);
        to_h   = expect_half(to_code);
        @(negedge clk_i); master_i = 1'b1; div_code_i = 4'(from_code);
        repeat (100 + skew) @(negedge clk_i);
        div_code_i = 4'(to_code);
        old_seen = 0;
        for (int k = 0; k < 8; k++) begin
            measure(per, hi);
            if (per == from_h) old_seen++;
            checks++;
            if (per != from_h && per != to_h) begin
                errors++;
                $display("FAIL R5 period after change: actual %0d expected %0d or %0d",
                         per, from_h, to_h);
            end
            check("R5", "high time after change", hi, per / 2);
        end
        check_le("R5", "old-length periods after change", old_seen, 2);
        check("R5", "final period", per, to_h);
    endtask

    // R6: one strobe per rising edge in master mode
    task automatic t_strobe(input int code);
        int stbs, diff;
        @(negedge clk_i); master_i = 1'b1; div_code_i = 4'(code);
        repeat (80) @(negedge clk_i);
        stbs = 0; rise_cnt = 0; rise_en = 1'b1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk_i);
            if (bit_stb_o) stbs++;
        end
        rise_en = 1'b0;
        diff = (stbs > rise_cnt) ? stbs - rise_cnt : rise_cnt - stbs;
        check_le("R6", $sformatf("code %0d strobe/edge mismatch", code), diff, 1);
        check("R6", $sformatf("code %0d edges seen", code), (rise_cnt >= 800 / expect_half(code) - 1) ? 1 : 0, 1);
    endtask

    // R7, R8: slave bypass and strobes
    task automatic t_slave();
        int stbs, run;
        @(negedge clk_i); master_i = 1'b0; bclk_ext_i = 1'b0;
        repeat (6) @(negedge clk_i);
        stbs = 0;
        for (int p = 0; p < 20; p++) begin
            for (int ph = 0; ph < 2; ph++) begin
                bclk_ext_i = ~bclk_ext_i;
                div_code_i = 4'((p * 3 + ph) % 16);
                #1;
                check("R7", "bypass level", int'(bclk_o), int'(bclk_ext_i));
                run = 0;
                for (int c = 0; c < 7; c++) begin
                    @(negedge clk_i);
                    if (bit_stb_o) begin
                        stbs++;
                        if (ph == 0 && c > 2) run++;
                    end
                end
                if (ph == 0) check("R8", "strobe latency over three cycles", run, 0);
            end
        end
        check("R8", "slave strobe count", stbs, 20);
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 16; c++) t_ratio(c);
        t_follow();
        t_change(5, 2, 3);
        t_change(5, 1, 8);
        t_change(2, 9, 1);
        t_strobe(3);
        t_strobe(5);
        t_strobe(0);
        t_slave();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule